// File: doc/BRIEF.md
# Transmit DMA Engine Sequencer

This block steers a transmit DMA engine through its life cycle: powered down, waiting for the hardware to come up, idle, running, waiting for a halt to settle, and the two cleanup waits (hardware side, then software side). It reacts only to one-cycle event strobes from software and from the engine. It answers with a registered state, a registered four-bit control word for the engine, and one-cycle action strobes. These strobes ask other logic to start a software cleanup, bring the hardware up, clean the hardware, or tear the engine down.

A sticky run-request flag remembers whether software wants the engine running. The flag is updated in the transitional states, so a start-up that completes while a run is pending lands directly in running, and otherwise lands in idle. The control word for each state comes from a parameter table. Each table entry may also force the run-request flag on or off when its state is entered. Two kinds of error halt are accepted while running. One goes straight into software cleanup. The other first waits for the engine to report that it has halted.

Top module: `dma_seq_ctrl`

## Requirements
- R1: While reset is held and on its release: state 0 (down), previous state 0, run flag 0, control word equal to the down entry of the table (0 with the default table), last event 15 (none), all action strobes 0.
- R2: Event bits on evt_i are: 0 go-down, 1 go-start, 2 hw-started, 3 go-run, 4 sw-cleaned, 5 hw-cleaned, 6 hw-halted, 7 go-idle, 8 error-halt-A, 9 error-halt-B, 10 tick. When several bits are set in one cycle, only the lowest-numbered one is acted on and recorded.
- R3: In down (0), go-start moves to start-up wait (1); go-run sets the run flag and also moves to 1; sw-cleaned pulses teardown and stays in 0.
- R4: In start-up wait (1), hw-started moves to running (6) if the run flag is set, otherwise to idle (2); go-run sets and go-idle clears the run flag without a state change.
- R5: Idle (2) with go-run moves to running (6) and sets the run flag; running with go-idle moves to halt wait (5) and clears the run flag.
- R6: In running, hw-halted or error-halt-A moves to software-cleanup wait (3) with a cleanup pulse; error-halt-B moves to halt wait (5) with no pulse.
- R7: Halt wait (5) with hw-halted moves to hardware-cleanup wait (4) and pulses hardware cleanup. State 4 with hw-cleaned moves to 3 and pulses cleanup. State 3 with sw-cleaned moves to 1 and pulses hardware bring-up. States 3, 4 and 5 take go-run (set flag) and go-idle (clear flag) without moving.
- R8: Go-down moves to down (0): from 1 or 2 with a teardown pulse, from 4, 5 or 6 with a cleanup pulse, from 3 with no pulse.
- R9: On each state change the control word (bit0 enable, bit1 interrupt enable, bit2 halt, bit3 drain) is reloaded from the new state's table entry. The entry's force-set bit sets the run flag and its force-clear bit clears it, with set taking priority, overriding the event's own flag effect. The default words are: 0 for down; halt (4) for states 1 to 4; enable, halt and drain (13) for halt wait; enable and interrupt enable (3) with force-set for running. The down entry carries force-clear.
- R10: An event not listed for the current state, or no event, leaves state, previous state, run flag and control word unchanged and raises no action strobe.
- R11: Every cycle with an event updates the last-event output to that event's bit number, tick (10) included; a cycle without an event keeps it.
- R12: On each state change the previous-state output takes the state that was left.
- R13: All results are registered and appear one clock after the strobe. Each action strobe lasts exactly one cycle, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 11 | One-cycle event strobes, bit map per R2 |
| state_o | output | 3 | Current state code |
| prev_state_o | output | 3 | State left on the last transition |
| ctrl_o | output | 4 | Engine control word per R9 |
| run_req_o | output | 1 | Sticky run-request flag |
| last_evt_o | output | 4 | Bit number of last accepted event, 15 if none |
| act_cleanup_o | output | 1 | Start software cleanup strobe |
| act_hwstart_o | output | 1 | Start hardware bring-up strobe |
| act_hwclean_o | output | 1 | Start hardware cleanup strobe |
| act_teardown_o | output | 1 | Teardown strobe |

## Verification
Every output of this block is due exactly one rising edge after the strobe that causes it: state, previous state, control word, run flag, last event and action strobes all change together. The bench drives a strobe just after a falling edge. It advances its behavioural model by one step for that strobe, then compares every output at the next falling edge. An action strobe expected in one comparison is expected low in the following one. Directed walks cover each transition, and a long pseudo-random walk with occasional double strobes covers ignored events and priority.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
    localparam int NUM_EVT = 11;
    localparam int EVT_W   = 4;
    localparam int NUM_ST  = 7;
    localparam int ST_W    = 3;
    localparam int CTRL_W  = 4;
    localparam int ENTRY_W = CTRL_W + 2;
    localparam int TABLE_W = NUM_ST * ENTRY_W;

    // entry layout: [3:0] control word, [4] force run flag set, [5] force clear
    localparam logic [TABLE_W-1:0] DEF_TABLE = {
        6'b01_0011,   // running
        6'b00_1101,   // halt wait
        6'b00_0100,   // hardware cleanup wait
        6'b00_0100,   // software cleanup wait
        6'b00_0100,   // idle
        6'b00_0100,   // start-up wait
        6'b10_0000    // down
    };

    typedef enum logic [ST_W-1:0] {
        ST_OFF    = 3'd0,
        ST_BRINGUP= 3'd1,
        ST_IDLE   = 3'd2,
        ST_SWCLN  = 3'd3,
        ST_HWCLN  = 3'd4,
        ST_HALTW  = 3'd5,
        ST_RUN    = 3'd6
    } st_e;

    typedef enum logic [EVT_W-1:0] {
        EV_DOWN   = 4'd0,
        EV_START  = 4'd1,
        EV_HWUP   = 4'd2,
        EV_RUN    = 4'd3,
        EV_SWDONE = 4'd4,
        EV_HWDONE = 4'd5,
        EV_HALTED = 4'd6,
        EV_IDLE   = 4'd7,
        EV_ERRA   = 4'd8,
        EV_ERRB   = 4'd9,
        EV_TICK   = 4'd10,
        EV_NONE   = 4'd15
    } ev_e;

    typedef struct packed {
        st_e               state;
        st_e               prev;
        logic              run;
        logic [CTRL_W-1:0] ctrl;
        ev_e               last;
        logic              cleanup;
        logic              hwstart;
        logic              hwclean;
        logic              teardown;
    } seq_t;
endpackage

// File: rtl/dmactl_evt_sel.sv
module dmactl_evt_sel
    import dmactl_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic [N-1:0] strobe_i,
    output ev_e          pick_o
);
    // lowest set bit wins
    always_comb begin
        pick_o = EV_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (strobe_i[i]) pick_o = ev_e'(EVT_W'(i));
        end
    end
endmodule

// File: rtl/dmactl_state_lut.sv
module dmactl_state_lut
    import dmactl_pkg::*;
#(
    parameter int                      NST   = NUM_ST,
    parameter int                      EW    = ENTRY_W,
    parameter logic [NST*EW-1:0]       TABLE = DEF_TABLE
) (
    input  st_e               st_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              set_o,
    output logic              clr_o
);
    logic [EW-1:0] entry [NST];
    logic [EW-1:0] sel;

    for (genvar g = 0; g < NST; g++) begin : g_entry
        assign entry[g] = TABLE[g*EW +: EW];
    end

    always_comb begin
        sel = '0;
        for (int k = 0; k < NST; k++) begin
            if (int'(st_i) == k) sel = entry[k];
        end
    end

    assign ctrl_o = sel[CTRL_W-1:0];
    assign set_o  = sel[CTRL_W];
    assign clr_o  = sel[CTRL_W+1];
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dmactl_pkg::*;
#(
    parameter logic [TABLE_W-1:0] ACT_TABLE = DEF_TABLE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic [ST_W-1:0]    state_o,
    output logic [ST_W-1:0]    prev_state_o,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic               run_req_o,
    output logic [EVT_W-1:0]   last_evt_o,
    output logic               act_cleanup_o,
    output logic               act_hwstart_o,
    output logic               act_hwclean_o,
    output logic               act_teardown_o
);
    localparam logic [CTRL_W-1:0] RST_CTRL = ACT_TABLE[CTRL_W-1:0];

    seq_t              seq_d, seq_q;
    ev_e               pick;
    st_e               nxt;
    logic              moved;
    logic [CTRL_W-1:0] lut_ctrl;
    logic              lut_set, lut_clr;

    dmactl_evt_sel #(.N(NUM_EVT)) u_sel (
        .strobe_i (evt_i),
        .pick_o   (pick)
    );

    dmactl_state_lut #(.NST(NUM_ST), .EW(ENTRY_W), .TABLE(ACT_TABLE)) u_lut (
        .st_i   (nxt),
        .ctrl_o (lut_ctrl),
        .set_o  (lut_set),
        .clr_o  (lut_clr)
    );

    always_comb begin
        seq_d          = seq_q;
        seq_d.cleanup  = 1'b0;
        seq_d.hwstart  = 1'b0;
        seq_d.hwclean  = 1'b0;
        seq_d.teardown = 1'b0;
        nxt            = seq_q.state;
        moved          = 1'b0;
        if (pick != EV_NONE) seq_d.last = pick;

        case (seq_q.state)
            ST_OFF: begin
                case (pick)
                    EV_RUN:    begin seq_d.run = 1'b1; nxt = ST_BRINGUP; moved = 1'b1; end
                    EV_START:  begin nxt = ST_BRINGUP; moved = 1'b1; end
                    EV_SWDONE: seq_d.teardown = 1'b1;
                    default: ;
                endcase
            end
            ST_BRINGUP: begin
                case (pick)
                    EV_DOWN: begin nxt = ST_OFF; moved = 1'b1; seq_d.teardown = 1'b1; end
                    EV_HWUP: begin nxt = seq_q.run ? ST_RUN : ST_IDLE; moved = 1'b1; end
                    EV_RUN:  seq_d.run = 1'b1;
                    EV_IDLE: seq_d.run = 1'b0;
                    default: ;
                endcase
            end
            ST_IDLE: begin
                case (pick)
                    EV_DOWN: begin nxt = ST_OFF; moved = 1'b1; seq_d.teardown = 1'b1; end
                    EV_RUN:  begin nxt = ST_RUN; moved = 1'b1; seq_d.run = 1'b1; end
                    default: ;
                endcase
            end
            ST_SWCLN: begin
                case (pick)
                    EV_DOWN:   begin nxt = ST_OFF; moved = 1'b1; end
                    EV_RUN:    seq_d.run = 1'b1;
                    EV_IDLE:   seq_d.run = 1'b0;
                    EV_SWDONE: begin nxt = ST_BRINGUP; moved = 1'b1; seq_d.hwstart = 1'b1; end
                    default: ;
                endcase
            end
            ST_HWCLN: begin
                case (pick)
                    EV_DOWN:   begin nxt = ST_OFF; moved = 1'b1; seq_d.cleanup = 1'b1; end
                    EV_RUN:    seq_d.run = 1'b1;
                    EV_IDLE:   seq_d.run = 1'b0;
                    EV_HWDONE: begin nxt = ST_SWCLN; moved = 1'b1; seq_d.cleanup = 1'b1; end
                    default: ;
                endcase
            end
            ST_HALTW: begin
                case (pick)
                    EV_DOWN:   begin nxt = ST_OFF; moved = 1'b1; seq_d.cleanup = 1'b1; end
                    EV_RUN:    seq_d.run = 1'b1;
                    EV_IDLE:   seq_d.run = 1'b0;
                    EV_HALTED: begin nxt = ST_HWCLN; moved = 1'b1; seq_d.hwclean = 1'b1; end
                    default: ;
                endcase
            end
            ST_RUN: begin
                case (pick)
                    EV_DOWN:   begin nxt = ST_OFF; moved = 1'b1; seq_d.cleanup = 1'b1; end
                    EV_HALTED: begin nxt = ST_SWCLN; moved = 1'b1; seq_d.cleanup = 1'b1; end
                    EV_ERRA:   begin nxt = ST_SWCLN; moved = 1'b1; seq_d.cleanup = 1'b1; end
                    EV_ERRB:   begin nxt = ST_HALTW; moved = 1'b1; end
                    EV_IDLE:   begin nxt = ST_HALTW; moved = 1'b1; seq_d.run = 1'b0; end
                    default: ;
                endcase
            end
            default: begin
                nxt   = ST_OFF;
                moved = 1'b1;
            end
        endcase

        if (moved) begin
            seq_d.state = nxt;
            seq_d.prev  = seq_q.state;
            seq_d.ctrl  = lut_ctrl;
            if (lut_set)      seq_d.run = 1'b1;
            else if (lut_clr) seq_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state    <= ST_OFF;
            seq_q.prev     <= ST_OFF;
            seq_q.run      <= 1'b0;
            seq_q.ctrl     <= RST_CTRL;
            seq_q.last     <= EV_NONE;
            seq_q.cleanup  <= 1'b0;
            seq_q.hwstart  <= 1'b0;
            seq_q.hwclean  <= 1'b0;
            seq_q.teardown <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o        = seq_q.state;
    assign prev_state_o   = seq_q.prev;
    assign ctrl_o         = seq_q.ctrl;
    assign run_req_o      = seq_q.run;
    assign last_evt_o     = seq_q.last;
    assign act_cleanup_o  = seq_q.cleanup;
    assign act_hwstart_o  = seq_q.hwstart;
    assign act_hwclean_o  = seq_q.hwclean;
    assign act_teardown_o = seq_q.teardown;

    // at most one action strobe at a time
    assert_one_action_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_cleanup_o, act_hwstart_o, act_hwclean_o, act_teardown_o}));

    // quiet input keeps the sequencer where it is
    assert_quiet_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> ($stable(state_o) && $stable(run_req_o) && $stable(ctrl_o)));

    // start-up completion with a pending run request lands in running
    assert_pending_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_BRINGUP && pick == EV_HWUP && seq_q.run) |=> (state_o == ST_RUN));

    // start-up completion without request lands in idle
    assert_no_run_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_BRINGUP && pick == EV_HWUP && !seq_q.run) |=> (state_o == ST_IDLE));

    // previous state follows every move
    assert_prev_tracks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |-> (prev_state_o == $past(state_o)));

    // teardown only ever appears in the down state
    assert_teardown_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_teardown_o |-> (state_o == ST_OFF));

    // hardware cleanup strobe accompanies the hardware cleanup wait
    assert_hwclean_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        act_hwclean_o |-> (state_o == ST_HWCLN));

    // bring-up strobe accompanies start-up wait
    assert_hwstart_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        act_hwstart_o |-> (state_o == ST_BRINGUP));
endmodule

// File: tb/sim_dma_seq_ctrl.sv
module sim_dma_seq_ctrl;
    localparam int PERIOD = 10;
    localparam int NEV    = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NEV-1:0]  evt = '0;
    logic [2:0]      st, pst;
    logic [3:0]      ctrl, last;
    logic            run, a_cl, a_hs, a_hc, a_td;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // behavioural reference
    int m_st, m_prev, m_run, m_ctrl, m_last;
    int m_cl, m_hs, m_hc, m_td;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(PERIOD/2) clk = ~clk;

    dma_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .state_o(st), .prev_state_o(pst), .ctrl_o(ctrl), .run_req_o(run),
        .last_evt_o(last), .act_cleanup_o(a_cl), .act_hwstart_o(a_hs),
        .act_hwclean_o(a_hc), .act_teardown_o(a_td)
    );

    function automatic int word_for(int s);
        case (s)
            0:       return 0;
            5:       return 13;
            6:       return 3;
            default: return 4;
        endcase
    endfunction

    task automatic model_reset();
        m_st = 0; m_prev = 0; m_run = 0; m_ctrl = word_for(0); m_last = 15;
        m_cl = 0; m_hs = 0; m_hc = 0; m_td = 0;
    endtask

    task automatic model_step(logic [NEV-1:0] ev);
        int e = -1;
        int ns = m_st;
        for (int i = NEV - 1; i >= 0; i--) if (ev[i]) e = i;
        m_cl = 0; m_hs = 0; m_hc = 0; m_td = 0;
        if (e >= 0) m_last = e;
        if (m_st == 0) begin
            if (e == 1) ns = 1;
            else if (e == 3) begin m_run = 1; ns = 1; end
            else if (e == 4) m_td = 1;
        end else if (m_st == 1) begin
            if (e == 0) begin ns = 0; m_td = 1; end
            else if (e == 2) ns = (m_run != 0) ? 6 : 2;
            else if (e == 3) m_run = 1;
            else if (e == 7) m_run = 0;
        end else if (m_st == 2) begin
            if (e == 0) begin ns = 0; m_td = 1; end
            else if (e == 3) begin ns = 6; m_run = 1; end
        end else if (m_st == 6) begin
            if (e == 0) begin ns = 0; m_cl = 1; end
            else if (e == 6 || e == 8) begin ns = 3; m_cl = 1; end
            else if (e == 9) ns = 5;
            else if (e == 7) begin ns = 5; m_run = 0; end
        end else begin
            if (e == 3) m_run = 1;
            else if (e == 7) m_run = 0;
            else if (e == 0) begin ns = 0; m_cl = (m_st != 3) ? 1 : 0; end
            else if (m_st == 3 && e == 4) begin ns = 1; m_hs = 1; end
            else if (m_st == 4 && e == 5) begin ns = 3; m_cl = 1; end
            else if (m_st == 5 && e == 6) begin ns = 4; m_hc = 1; end
        end
        if (ns != m_st) begin
            m_prev = m_st;
            m_st   = ns;
            m_ctrl = word_for(ns);
            if (ns == 6) m_run = 1;
            if (ns == 0) m_run = 0;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(tag, "state", int'(st), m_st);
        chk(tag, "run flag", int'(run), m_run);
        chk("R12", "prev state", int'(pst), m_prev);
        chk("R9", "control word", int'(ctrl), m_ctrl);
        chk("R11", "last event", int'(last), m_last);
        chk("R13", "cleanup strobe", int'(a_cl), m_cl);
        chk("R13", "bring-up strobe", int'(a_hs), m_hs);
        chk("R13", "hw cleanup strobe", int'(a_hc), m_hc);
        chk("R13", "teardown strobe", int'(a_td), m_td);
    endtask

    task automatic cyc(string req, logic [NEV-1:0] ev);
        tag = req;
        evt = ev;
        model_step(ev);
        @(negedge clk);
        evt = '0;
        compare_all();
    endtask

    function automatic logic [NEV-1:0] bit_of(int b);
        return NEV'(1) << b;
    endfunction

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R1";
        compare_all();
        rst_n = 1'b1;
        compare_all();

        cyc("R3", bit_of(4));            // teardown in down
        cyc("R3", bit_of(1));            // to start-up wait
        cyc("R4", bit_of(2));            // idle, no request
        cyc("R5", bit_of(3));            // running
        cyc("R5", bit_of(7));            // halt wait, flag cleared
        cyc("R7", bit_of(6));            // hw cleanup wait
        cyc("R7", bit_of(3));            // flag set, no move
        cyc("R7", bit_of(5));            // sw cleanup wait
        cyc("R7", bit_of(4));            // bring-up
        cyc("R4", bit_of(2));            // pending request -> running
        cyc("R6", bit_of(8));            // error A
        cyc("R8", bit_of(0));            // down silently
        cyc("R3", bit_of(3));            // go-run from down
        cyc("R4", bit_of(7));            // clear request
        cyc("R4", bit_of(3));            // set request
        cyc("R4", bit_of(2));            // running
        cyc("R6", bit_of(9));            // error B -> halt wait
        cyc("R8", bit_of(0));            // down with cleanup
        cyc("R3", bit_of(1));
        cyc("R8", bit_of(0));            // down with teardown
        cyc("R10", bit_of(6));           // ignored in down
        cyc("R10", bit_of(10));          // tick recorded only
        cyc("R10", '0);
        cyc("R2", bit_of(1) | bit_of(0)); // go-down wins, stays down
        cyc("R2", bit_of(2) | bit_of(1)); // go-start wins
        cyc("R2", bit_of(2) | bit_of(7)); // hw-started wins -> idle
        cyc("R8", bit_of(0));             // idle -> down, teardown

        for (int n = 0; n < 4000; n++) begin
            logic [NEV-1:0] ev = '0;
            lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
            if (lfsr[3:0] >= 4'd5) begin
                ev = bit_of(int'(lfsr[11:8]) % NEV);
                if (lfsr[15:13] == 3'd0) ev |= bit_of(int'(lfsr[20:17]) % NEV);
            end
            cyc("R10", ev);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule